// File: doc/BRIEF.md
# Paged Receive Ring Buffer Manager

This block keeps received frames in a circular byte memory that is cut into 256-byte pages. Each page is named by a 12-bit page number, and a byte is reached at page × 256 + offset. Frame bytes arrive as a valid/data/last stream. The last byte carries a status byte. The block stores each frame from the current write page onward. It puts a packed 4-byte header in the first four bytes of that page, and the header links to the page where the next frame will start. When the data runs off the top page of the ring, it continues at the bottom page.

The host reads headers and payload through a byte address port, and the data comes back one cycle later. The host frees space by loading the read page register with the link it found in a header. It can also program the two ring bounds and the write page through a small byte-wide register port. If a frame cannot fit in front of the read page, the block drops it and raises a buffer-full event. The status byte is stored exactly as given. In it, bit 0 flags a full buffer, bits 1 to 3 mark CRC, alignment and FIFO overrun faults, bit 4 marks a watchdog cut, bit 5 marks multicast, bit 6 marks a runt and bit 7 marks a general receive error.

Top module: `rxr_ring_mgr`

## Requirements
- R1: After reset the bottom page is 0x001, the top page is 0x00F, the write page and the read page are both 0x001, and buf_empty is 1.
- R2: Register port: reg_addr 0/1 select the bottom page, 2/3 the top page, 4/5 the write page and 6/7 the read page. An even address holds bits 7:0. The odd address holds bits 11:8 in data bits 3:0 and reads zero in bits 7:4. A write takes effect at the clock edge, and reg_rdata is combinational on reg_addr.
- R3: The bytes of a frame are stored in arrival order, starting at offset 4 of the page held in the write page register. The host reads the byte at rd_addr = page × 256 + offset on rd_data one cycle after presenting the address.
- R4: When a frame is accepted, its header is written little-endian at offsets 0 to 3 of its first page. Header bits 11:0 hold the next page, bits 23:12 hold the byte count of the frame (FCS included) and bits 31:24 hold the status byte from the last beat.
- R5: When a frame is accepted, the write page becomes the page after the one holding the last byte, and store_evt pulses for one cycle after that edge. A commit overrides a register write to the write page in the same cycle.
- R6: After the byte at offset 255 of the top page, storage goes on at offset 0 of the bottom page. The page after the top page is the bottom page.
- R7: A frame is dropped if a byte would open a page equal to the read page, or if its next page would equal the read page. On a drop, full_evt pulses for one cycle, the write page stays where it was, nothing is written on the read page and the rest of the frame is ignored.
- R8: buf_empty is 1 exactly when the read page equals the write page.
- R9: If a read page write and a frame's last byte fall in the same cycle, the drop decision uses the read page from before the write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of the frame |
| in_status | input | 8 | Receive status, sampled with in_last |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| rd_addr | input | 20 | Host byte address (page × 256 + offset) |
| rd_data | output | 8 | Byte at rd_addr, one cycle later |
| buf_empty | output | 1 | Read page equals write page |
| store_evt | output | 1 | A frame was accepted |
| full_evt | output | 1 | A frame was dropped because the ring was full |

## Verification
Two functions can land in the same cycle: the host releasing space by rewriting the read page, and the write side deciding whether to accept the final byte of a frame. The bench forces this overlap. It puts a read page write on the very beat that carries in_last, for a frame whose next page equals the old read page. Its behavioural model then expects a drop against the old value, and expects the new read page value to show up in the register right after. A second frame then shows that acceptance follows the new read page.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int PG_W     = 12;
  localparam int OFF_W    = 8;
  localparam int HI_W     = PG_W - OFF_W;
  localparam int HDR_OFF  = 4;
  localparam int ADDR_W   = PG_W + OFF_W;

  typedef struct packed {
    logic [PG_W-1:0]  pg;
    logic [OFF_W-1:0] off;
  } baddr_t;

  typedef enum logic [2:0] {
    SEL_BOT_L = 3'd0, SEL_BOT_H = 3'd1,
    SEL_TOP_L = 3'd2, SEL_TOP_H = 3'd3,
    SEL_WP_L  = 3'd4, SEL_WP_H  = 3'd5,
    SEL_RP_L  = 3'd6, SEL_RP_H  = 3'd7
  } reg_sel_e;

  // page that follows pg inside the ring [bot, top]
  function automatic logic [PG_W-1:0] ring_next_page(input logic [PG_W-1:0] pg,
                                                     input logic [PG_W-1:0] bot,
                                                     input logic [PG_W-1:0] top);
    return (pg == top) ? bot : pg + 1'b1;
  endfunction

  // byte address that follows a inside the ring
  function automatic baddr_t ring_step(input baddr_t a,
                                       input logic [PG_W-1:0] bot,
                                       input logic [PG_W-1:0] top);
    baddr_t r;
    if (&a.off) begin
      r.pg  = ring_next_page(a.pg, bot, top);
      r.off = '0;
    end else begin
      r.pg  = a.pg;
      r.off = a.off + 1'b1;
    end
    return r;
  endfunction

  function automatic logic [31:0] hdr_pack(input logic [PG_W-1:0] nxt,
                                           input logic [PG_W-1:0] len,
                                           input logic [7:0] st);
    return {st, len, nxt};
  endfunction
endpackage

// File: rtl/rxr_cfg_regs.sv
module rxr_cfg_regs import rxr_pkg::*; #(
  parameter logic [PG_W-1:0] DEF_BOT = 12'h001,
  parameter logic [PG_W-1:0] DEF_TOP = 12'h00F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            commit,
  input  logic [PG_W-1:0] commit_pg,
  output logic [PG_W-1:0] bot,
  output logic [PG_W-1:0] top,
  output logic [PG_W-1:0] wp,
  output logic [PG_W-1:0] rp
);
  localparam int PAD_W = 8 - HI_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bot <= DEF_BOT;
      top <= DEF_TOP;
      wp  <= DEF_BOT;
      rp  <= DEF_BOT;
    end else begin
      if (reg_we) begin
        case (reg_sel_e'(reg_addr))
          SEL_BOT_L: bot[OFF_W-1:0]    <= reg_wdata;
          SEL_BOT_H: bot[PG_W-1:OFF_W] <= reg_wdata[HI_W-1:0];
          SEL_TOP_L: top[OFF_W-1:0]    <= reg_wdata;
          SEL_TOP_H: top[PG_W-1:OFF_W] <= reg_wdata[HI_W-1:0];
          SEL_WP_L:  wp[OFF_W-1:0]     <= reg_wdata;
          SEL_WP_H:  wp[PG_W-1:OFF_W]  <= reg_wdata[HI_W-1:0];
          SEL_RP_L:  rp[OFF_W-1:0]     <= reg_wdata;
          SEL_RP_H:  rp[PG_W-1:OFF_W]  <= reg_wdata[HI_W-1:0];
        endcase
      end
      // an accepted frame overrides a software write to the write page
      if (commit) wp <= commit_pg;
    end
  end

  always_comb begin
    case (reg_sel_e'(reg_addr))
      SEL_BOT_L: reg_rdata = bot[OFF_W-1:0];
      SEL_BOT_H: reg_rdata = {{PAD_W{1'b0}}, bot[PG_W-1:OFF_W]};
      SEL_TOP_L: reg_rdata = top[OFF_W-1:0];
      SEL_TOP_H: reg_rdata = {{PAD_W{1'b0}}, top[PG_W-1:OFF_W]};
      SEL_WP_L:  reg_rdata = wp[OFF_W-1:0];
      SEL_WP_H:  reg_rdata = {{PAD_W{1'b0}}, wp[PG_W-1:OFF_W]};
      SEL_RP_L:  reg_rdata = rp[OFF_W-1:0];
      SEL_RP_H:  reg_rdata = {{PAD_W{1'b0}}, rp[PG_W-1:OFF_W]};
    endcase
  end

  // R2: a low-byte write to the read page lands on the next edge
  p_rp_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd6) |=> (rp[OFF_W-1:0] == $past(reg_wdata)));
endmodule

// File: rtl/rxr_wr_ctrl.sv
module rxr_wr_ctrl import rxr_pkg::*; #(
  parameter  int MEM_PAGES = 16,
  localparam int PIDX      = $clog2(MEM_PAGES),
  localparam int IDX_W     = PIDX + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic [7:0]       in_status,
  input  logic [PG_W-1:0]  bot,
  input  logic [PG_W-1:0]  top,
  input  logic [PG_W-1:0]  wp,
  input  logic [PG_W-1:0]  rp,
  output logic             data_we,
  output logic [IDX_W-1:0] data_idx,
  output logic [7:0]       data_byte,
  output logic             hdr_we,
  output logic [IDX_W-1:0] hdr_base,
  output logic [31:0]      hdr_word,
  output logic             commit,
  output logic [PG_W-1:0]  commit_pg,
  output logic             store_evt,
  output logic             full_evt
);
  logic            active_q, drop_q;
  logic [PG_W-1:0] head_q, cnt_q;
  baddr_t          addr_q;

  baddr_t          cur;
  logic [PG_W-1:0] head, nxt, len;
  logic            hit_page, hit_end, drop_now;
  logic            unused_head_hi;

  always_comb begin
    if (active_q) begin
      cur  = addr_q;
      head = head_q;
    end else begin
      cur.pg  = wp;
      cur.off = OFF_W'(HDR_OFF);
      head    = wp;
    end
  end

  assign nxt      = ring_next_page(cur.pg, bot, top);
  assign len      = cnt_q + 1'b1;
  // named events: opening the read page, or linking onto it
  assign hit_page = in_valid && !drop_q && (cur.off == '0) && (cur.pg == rp);
  assign hit_end  = in_valid && in_last && !drop_q && !hit_page && (nxt == rp);
  assign drop_now = hit_page || hit_end;
  assign commit   = in_valid && in_last && !drop_q && !drop_now;

  assign data_we   = in_valid && !drop_q && !hit_page;
  assign data_idx  = {cur.pg[PIDX-1:0], cur.off};
  assign data_byte = in_data;
  assign hdr_we    = commit;
  assign hdr_base  = {head[PIDX-1:0], {OFF_W{1'b0}}};
  assign hdr_word  = hdr_pack(nxt, len, in_status);
  assign commit_pg = nxt;
  assign unused_head_hi = ^head[PG_W-1:PIDX];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      drop_q    <= 1'b0;
      head_q    <= '0;
      cnt_q     <= '0;
      addr_q    <= '0;
      store_evt <= 1'b0;
      full_evt  <= 1'b0;
    end else begin
      store_evt <= commit;
      full_evt  <= drop_now;
      if (in_valid) begin
        if (in_last) begin
          active_q <= 1'b0;
          drop_q   <= 1'b0;
          cnt_q    <= '0;
        end else begin
          active_q <= 1'b1;
          head_q   <= head;
          addr_q   <= ring_step(cur, bot, top);
          cnt_q    <= len;
          drop_q   <= drop_q | drop_now;
        end
      end
    end
  end
endmodule

// File: rtl/rxr_store.sv
module rxr_store import rxr_pkg::*; #(
  parameter  int MEM_PAGES = 16,
  localparam int PIDX      = $clog2(MEM_PAGES),
  localparam int IDX_W     = PIDX + OFF_W,
  localparam int DEPTH     = MEM_PAGES << OFF_W
) (
  input  logic             clk,
  input  logic             data_we,
  input  logic [IDX_W-1:0] data_idx,
  input  logic [7:0]       data_byte,
  input  logic             hdr_we,
  input  logic [IDX_W-1:0] hdr_base,
  input  logic [31:0]      hdr_word,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (data_we) mem[data_idx] <= data_byte;
    if (hdr_we) begin
      for (int b = 0; b < HDR_OFF; b++)
        mem[hdr_base + IDX_W'(b)] <= hdr_word[8*b +: 8];
    end
    rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/rxr_ring_mgr.sv
module rxr_ring_mgr import rxr_pkg::*; #(
  parameter int              MEM_PAGES = 16,
  parameter logic [PG_W-1:0] DEF_BOT   = 12'h001,
  parameter logic [PG_W-1:0] DEF_TOP   = 12'h00F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic [7:0]        in_status,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              buf_empty,
  output logic              store_evt,
  output logic              full_evt
);
  localparam int PIDX  = $clog2(MEM_PAGES);
  localparam int IDX_W = PIDX + OFF_W;

  logic [PG_W-1:0]  bot, top, wp, rp, commit_pg;
  logic             commit, data_we, hdr_we;
  logic [IDX_W-1:0] data_idx, hdr_base, rd_idx;
  logic [7:0]       data_byte;
  logic [31:0]      hdr_word;
  logic             unused_rd_hi;

  rxr_cfg_regs #(.DEF_BOT(DEF_BOT), .DEF_TOP(DEF_TOP)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .commit(commit),
    .commit_pg(commit_pg), .bot(bot), .top(top), .wp(wp), .rp(rp));

  rxr_wr_ctrl #(.MEM_PAGES(MEM_PAGES)) u_wr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_status(in_status), .bot(bot), .top(top),
    .wp(wp), .rp(rp), .data_we(data_we), .data_idx(data_idx),
    .data_byte(data_byte), .hdr_we(hdr_we), .hdr_base(hdr_base),
    .hdr_word(hdr_word), .commit(commit), .commit_pg(commit_pg),
    .store_evt(store_evt), .full_evt(full_evt));

  assign rd_idx       = {rd_addr[OFF_W+PIDX-1:OFF_W], rd_addr[OFF_W-1:0]};
  assign unused_rd_hi = ^rd_addr[ADDR_W-1:OFF_W+PIDX];

  rxr_store #(.MEM_PAGES(MEM_PAGES)) u_mem (
    .clk(clk), .data_we(data_we), .data_idx(data_idx), .data_byte(data_byte),
    .hdr_we(hdr_we), .hdr_base(hdr_base), .hdr_word(hdr_word),
    .rd_idx(rd_idx), .rd_data(rd_data));

  assign buf_empty = (rp == wp);

  // R5: an accepted frame always moves the write page
  p_store_moves_wp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    store_evt |-> (wp != $past(wp)));
  // R7: a dropped frame leaves the write page alone
  p_drop_keeps_wp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full_evt && !$past(reg_we)) |-> $stable(wp));
  // R7: one frame never both commits and drops
  p_evt_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_evt && full_evt));
  // R8: an accepted frame cannot leave the ring looking empty
  p_store_not_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (store_evt && !$past(reg_we)) |-> !buf_empty);
endmodule

// File: tb/test_rxr_ring_mgr.sv
`timescale 1ns/1ps
module test_rxr_ring_mgr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_last = 1'b0, reg_we = 1'b0;
  logic [7:0]  in_data = '0, in_status = '0, reg_wdata = '0;
  logic [2:0]  reg_addr = '0;
  logic [19:0] rd_addr = '0;
  logic [7:0]  reg_rdata, rd_data;
  logic        buf_empty, store_evt, full_evt;

  always #2 clk = ~clk;

  rxr_ring_mgr i_rxr_ring_mgr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_status(in_status), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .buf_empty(buf_empty),
    .store_evt(store_evt), .full_evt(full_evt));

  int nchk = 0, nerr = 0;
  bit done = 0;

  // behavioural model
  int m_bot = 1, m_top = 15, m_wp = 1, m_rp = 1;
  bit [7:0] m_mem [4096];
  bit m_active = 0, m_drop = 0;
  int m_addr = 0, m_head = 0, m_cnt = 0;

  function automatic int midx(input int a);
    return ((a / 256) % 16) * 256 + (a % 256);
  endfunction

  task automatic chk(input string rq, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input bit [7:0] d, input bit l, input bit [7:0] st,
                     input bit we, input bit [2:0] ra, input bit [7:0] wd);
    int a, pg, off, nx, nwp;
    bit es, ef;
    es = 0; ef = 0; nwp = m_wp;
    in_valid = v; in_data = d; in_last = l; in_status = st;
    reg_we = we; reg_addr = ra; reg_wdata = wd;
    if (v) begin
      if (!m_active) begin a = m_wp * 256 + 4; m_head = m_wp; end
      else a = m_addr;
      pg = a / 256; off = a % 256;
      m_cnt++;
      if (!m_drop) begin
        if (off == 0 && pg == m_rp) begin m_drop = 1; ef = 1; end
        else begin
          m_mem[midx(a)] = d;
          if (l) begin
            nx = pg + 1;
            if (nx > m_top) nx = m_bot;
            if (nx == m_rp) ef = 1;
            else begin
              es = 1; nwp = nx;
              m_mem[midx(m_head*256)]   = nx % 256;
              m_mem[midx(m_head*256+1)] = ((m_cnt % 16) * 16) + (nx / 256);
              m_mem[midx(m_head*256+2)] = (m_cnt / 16) % 256;
              m_mem[midx(m_head*256+3)] = st;
            end
          end
        end
      end
      if (l) begin m_active = 0; m_drop = 0; m_cnt = 0; end
      else begin
        m_active = 1;
        m_addr = (a + 1 == (m_top + 1) * 256) ? m_bot * 256 : a + 1;
      end
    end
    if (we) begin
      case (ra)
        3'd0: m_bot = (m_bot & 'hF00) | wd;
        3'd1: m_bot = (m_bot & 'hFF) | ((wd % 16) * 256);
        3'd2: m_top = (m_top & 'hF00) | wd;
        3'd3: m_top = (m_top & 'hFF) | ((wd % 16) * 256);
        3'd4: m_wp  = (m_wp & 'hF00) | wd;
        3'd5: m_wp  = (m_wp & 'hFF) | ((wd % 16) * 256);
        3'd6: m_rp  = (m_rp & 'hF00) | wd;
        default: m_rp = (m_rp & 'hFF) | ((wd % 16) * 256);
      endcase
    end
    if (es) m_wp = nwp;  // R5: commit beats a write-page register write
    @(posedge clk);
    @(negedge clk);
    chk("R5 store_evt", int'(store_evt), int'(es));
    chk("R7 full_evt", int'(full_evt), int'(ef));
    chk("R8 buf_empty", int'(buf_empty), int'(m_wp == m_rp));
    in_valid = 0; in_last = 0; reg_we = 0;
  endtask

  task automatic send(input int n, input bit [7:0] st, input bit [7:0] seed,
                      input bit rw = 0, input bit [2:0] ra = 0, input bit [7:0] wd = 0);
    for (int i = 0; i < n; i++)
      cyc(1'b1, 8'(seed + i), i == n - 1, st, rw && (i == n - 1), ra, wd);
  endtask

  task automatic setreg(input bit [2:0] a, input bit [7:0] d);
    cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, a, d);
  endtask

  task automatic rr_chk(input bit [2:0] a, input int exp, input string rq);
    reg_addr = a;
    #1;
    chk(rq, int'(reg_rdata), exp);
    @(negedge clk);
  endtask

  task automatic rd_chk(input int a, input string rq);
    rd_addr = 20'(a);
    cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 3'd0, 8'h00);
    chk(rq, int'(rd_data), int'(m_mem[midx(a)]));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state through the register port (R2 layout)
    rr_chk(3'd0, 8'h01, "R1 bot lo");
    rr_chk(3'd1, 8'h00, "R1 bot hi");
    rr_chk(3'd2, 8'h0F, "R1 top lo");
    rr_chk(3'd3, 8'h00, "R1 top hi");
    rr_chk(3'd4, 8'h01, "R1 wp lo");
    rr_chk(3'd5, 8'h00, "R1 wp hi");
    rr_chk(3'd6, 8'h01, "R1 rp lo");
    rr_chk(3'd7, 8'h00, "R1 rp hi");
    chk("R1 buf_empty", int'(buf_empty), 1);

    // short frame at page 1
    send(10, 8'h42, 8'h10);
    for (int i = 0; i < 4; i++) rd_chk('h100 + i, "R4 header");
    rd_chk('h104, "R3 first byte");
    rd_chk('h10D, "R3 last byte");
    // frame that ends exactly on a page end
    send(252, 8'h81, 8'h30);
    rd_chk('h2FF, "R3 page end");
    rd_chk('h200, "R4 next link");
    // multi-page frame
    send(600, 8'h05, 8'h77);
    for (int i = 0; i < 4; i++) rd_chk('h300 + i, "R4 header long");
    rr_chk(3'd4, m_wp % 256, "R5 wp after frames");

    // release and shrink the ring to pages 1..8
    setreg(3'd6, 8'h06);
    setreg(3'd2, 8'h08);
    rr_chk(3'd2, 8'h08, "R2 top lo");
    rr_chk(3'd3, 8'h00, "R2 top hi");
    send(1000, 8'h20, 8'h01);
    rd_chk('h8FF, "R6 top page end");
    rd_chk('h100, "R6 wrapped byte");
    rd_chk('h600, "R6 header link");
    rr_chk(3'd4, 8'h02, "R6 wp after wrap");
    send(300, 8'h00, 8'h55);
    // opens the read page -> drop
    send(600, 8'h00, 8'h99);
    rd_chk('h600, "R7 read page untouched");
    rr_chk(3'd4, 8'h04, "R7 wp kept on page drop");
    // links onto the read page -> drop
    send(500, 8'h00, 8'hAA);
    rr_chk(3'd4, 8'h04, "R7 wp kept on end drop");
    send(200, 8'h11, 8'h3C);
    rd_chk('h400, "R7 recovery header");

    // same-cycle read page release and final byte
    send(10, 8'h66, 8'hC0, 1'b1, 3'd6, 8'h07);
    rr_chk(3'd6, 8'h07, "R9 rp written");
    rr_chk(3'd4, 8'h05, "R9 old rp decided drop");
    send(10, 8'h67, 8'hD0);
    rr_chk(3'd4, 8'h06, "R9 new rp allows commit");
    setreg(3'd6, 8'h06);
    // software move of the write page
    setreg(3'd4, 8'h03);
    send(5, 8'h19, 8'hE0);
    rd_chk('h300, "R2 wp write header");
    rd_chk('h304, "R2 wp write data");

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule